// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front-End

This block is the software-facing side of a serial port. A processor reaches it over a simple 32-bit bus with separate read and write strobes and a byte address whose two low bits are ignored. Received bytes arrive one per cycle on a byte-valid input and are held in a 16-entry receive FIFO. Transmit bytes written by software leave on a byte port with a one-cycle strobe. Bit-level framing, baud timing and DMA sit in other blocks.

Software can see the receive FIFO through two status/data words. The first returns the oldest byte and removes it. The second only looks at it. Both words also carry a data-available flag and two transmitter flags that always read as set. The interrupt section has a raw, a mask, an acknowledge and a masked register, and it drives one level interrupt line. The receive interrupt follows FIFO occupancy as a level. The transmit-done bit has a quirk: the first acknowledge after a transmit write cannot clear it.

Top module: `serial_regblock`

## Requirements
- R1: After reset every register reads 0 except the two status/data words, which read 0x0140_0000. After reset `irq` is low and `rx_space` is 0.
- R2: The offsets 0x00 (transmit control), 0x04 (transmit DMA enable), 0x08 (receive control), 0x1C (data out) and 0x2C (interrupt mask) are plain 32-bit read/write storage. Address bits [1:0] are ignored. The offsets 0x0C, 0x10, 0x14, 0x18, 0x28 and 0x3C read 0, and writes to them have no effect.
- R3: A status/data word has this layout: bits [7:0] hold the FIFO head byte, or 0 when the FIFO is empty. Bit 16 is 1 when the FIFO is non-empty. Bits 22 and 24 are always 1. All other bits are 0.
- R4: A read at 0x20 removes the head entry when the FIFO is non-empty and has no effect when it is empty. A read at 0x24 never changes the FIFO.
- R5: Bytes leave the FIFO in arrival order, and the order holds across the wrap of the 16-entry storage.
- R6: A byte that arrives while the FIFO holds 16 entries is dropped.
- R7: Bytes are accepted only while bit 3 of receive control is 1. In that state `rx_space` equals 16 minus the FIFO count; otherwise `rx_space` is 0.
- R8: Raw interrupt bit 3 (offset 0x34) is 1 exactly when the FIFO is non-empty, and an acknowledge cannot clear it.
- R9: A write to 0x1C drives the low data byte on `tx_byte` with `tx_strobe` high for the following cycle. It also sets raw interrupt bits 0 and 1 and sets a pending-transmit flag.
- R10: A write to 0x30 clears the raw bits that are set in the written value and stores the value it applied. While pending-transmit is set, bit 0 of that value is forced to 0 and pending-transmit is cleared.
- R11: The masked register (0x38) reads raw AND mask, and `irq` is high exactly when that value is non-zero.
- R12: Read data appears on `bus_rdata` in the cycle after the read strobe. A pop and an accepted push in the same cycle are both applied, so the count stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (6) | Byte address; bits [1:0] are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_space | output | CNT_W (5) | Free FIFO entries while the receiver is enabled, else 0 |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle pulse with tx_byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `bus_wr` and `bus_rd` never target the same offset in one cycle. They also assume that `bus_addr` is stable while a strobe is high. The assertions that tie the raw receive bit to the FIFO count rely on at most one acknowledge or data-out write per cycle. The bench raises each strobe for exactly one cycle and never overlaps two bus operations. The one exception is the push-with-pop case, which drives `rx_valid` together with a pop read because that overlap is the behaviour being checked.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int unsigned REG_W = 32;

    // word indices (byte offset / 4)
    localparam logic [3:0] IDX_TXCTL  = 4'h0;
    localparam logic [3:0] IDX_TXDMA  = 4'h1;
    localparam logic [3:0] IDX_RXCTL  = 4'h2;
    localparam logic [3:0] IDX_DOUT   = 4'h7;
    localparam logic [3:0] IDX_POP    = 4'h8;
    localparam logic [3:0] IDX_PEEK   = 4'h9;
    localparam logic [3:0] IDX_MASK   = 4'hB;
    localparam logic [3:0] IDX_ACK    = 4'hC;
    localparam logic [3:0] IDX_RAW    = 4'hD;
    localparam logic [3:0] IDX_MASKED = 4'hE;

    // status word bit positions
    localparam int unsigned ST_AVAIL = 16;
    localparam int unsigned ST_IDLE  = 22;
    localparam int unsigned ST_READY = 24;

    localparam int unsigned RX_EN_BIT  = 3;
    localparam int unsigned IRQ_RX_BIT = 3;
endpackage

// File: rtl/srb_rx_fifo.sv
module srb_rx_fifo #(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] head,
    output logic              empty,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_next
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             wpos;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push_ok, pop_ok;
    logic [PTR_W-1:0] head_idx;

    always_comb begin
        st_d     = st_q;
        push_ok  = push_req && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok   = pop_req && (st_q.cnt != '0);
        head_idx = st_q.wpos - st_q.cnt[PTR_W-1:0];
        if (push_ok) begin
            st_d.mem[st_q.wpos] = push_data;
            st_d.wpos           = st_q.wpos + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty      = (st_q.cnt == '0);
    assign head       = empty ? '0 : st_q.mem[head_idx];
    assign count      = st_q.cnt;
    assign count_next = st_d.cnt;

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(DEPTH) && !pop_req) |=> st_q.cnt == CNT_W'(DEPTH));
    assert_push_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(st_q.cnt));
endmodule

// File: rtl/srb_tx_port.sv
module srb_tx_port #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [BYTE_W-1:0] send_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_strobe
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              stb;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = send;
        if (send) st_d.data = send_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_byte   = st_q.data;
    assign tx_strobe = st_q.stb;

    assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        send |=> (tx_strobe && tx_byte == $past(send_byte)));
endmodule

// File: rtl/srb_irq_ctrl.sv
module srb_irq_ctrl
    import srb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dout_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    input  logic         rx_level_next,
    input  logic [W-1:0] mask,
    output logic [W-1:0] raw,
    output logic [W-1:0] ack_val,
    output logic [W-1:0] masked,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] raw;
        logic [W-1:0] ack;
        logic         pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [W-1:0] applied;

    always_comb begin
        st_d    = st_q;
        applied = wdata;
        if (dout_we) begin
            st_d.raw[1:0] = 2'b11;
            st_d.pend     = 1'b1;
        end
        if (ack_we) begin
            if (st_q.pend) begin
                applied[0] = 1'b0;
                st_d.pend  = 1'b0;
            end
            st_d.ack = applied;
            st_d.raw = st_q.raw & ~applied;
        end
        st_d.raw[IRQ_RX_BIT] = rx_level_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw     = st_q.raw;
    assign ack_val = st_q.ack;
    assign masked  = st_q.raw & mask;
    assign irq     = |masked;

    assert_dout_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_we |=> (raw[1:0] == 2'b11));
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !st_q.pend && !dout_we) |=>
            ((raw & $past(wdata) & ~(W'(1) << IRQ_RX_BIT)) == '0));
    assert_pend_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && st_q.pend) |=> (raw[0] == $past(raw[0])));
endmodule

// File: rtl/serial_regblock.sv
module serial_regblock
    import srb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 6,
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic [CNT_W-1:0]  rx_space,
    output logic [7:0]        tx_byte,
    output logic              tx_strobe,
    output logic              irq
);
    typedef struct packed {
        logic [REG_W-1:0] txctl;
        logic [REG_W-1:0] txdma;
        logic [REG_W-1:0] rxctl;
        logic [REG_W-1:0] dout;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [WORD_W-1:0] word;
    logic              wr_dout, wr_ack, push_req, pop_req;
    logic [7:0]        fifo_head;
    logic              fifo_empty;
    logic [CNT_W-1:0]  fifo_cnt, fifo_cnt_next;
    logic [REG_W-1:0]  raw, ack_val, masked, stat_word;

    assign word     = bus_addr[ADDR_W-1:2];
    assign wr_dout  = bus_wr && (word == WORD_W'(IDX_DOUT));
    assign wr_ack   = bus_wr && (word == WORD_W'(IDX_ACK));
    assign push_req = rx_valid && r_q.rxctl[RX_EN_BIT];
    assign pop_req  = bus_rd && (word == WORD_W'(IDX_POP));

    always_comb begin
        stat_word           = '0;
        stat_word[7:0]      = fifo_head;
        stat_word[ST_AVAIL] = !fifo_empty;
        stat_word[ST_IDLE]  = 1'b1;
        stat_word[ST_READY] = 1'b1;
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (word)
                WORD_W'(IDX_TXCTL): r_d.txctl = bus_wdata;
                WORD_W'(IDX_TXDMA): r_d.txdma = bus_wdata;
                WORD_W'(IDX_RXCTL): r_d.rxctl = bus_wdata;
                WORD_W'(IDX_DOUT):  r_d.dout  = bus_wdata;
                WORD_W'(IDX_MASK):  r_d.mask  = bus_wdata;
                default: ;
            endcase
        end
        if (bus_rd) begin
            case (word)
                WORD_W'(IDX_TXCTL):  r_d.rdata = r_q.txctl;
                WORD_W'(IDX_TXDMA):  r_d.rdata = r_q.txdma;
                WORD_W'(IDX_RXCTL):  r_d.rdata = r_q.rxctl;
                WORD_W'(IDX_DOUT):   r_d.rdata = r_q.dout;
                WORD_W'(IDX_POP):    r_d.rdata = stat_word;
                WORD_W'(IDX_PEEK):   r_d.rdata = stat_word;
                WORD_W'(IDX_MASK):   r_d.rdata = r_q.mask;
                WORD_W'(IDX_ACK):    r_d.rdata = ack_val;
                WORD_W'(IDX_RAW):    r_d.rdata = raw;
                WORD_W'(IDX_MASKED): r_d.rdata = masked;
                default:             r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign rx_space  = r_q.rxctl[RX_EN_BIT] ? (CNT_W'(DEPTH) - fifo_cnt) : '0;

    srb_rx_fifo #(.DEPTH(DEPTH), .BYTE_W(8)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (push_req),
        .push_data  (rx_byte),
        .pop_req    (pop_req),
        .head       (fifo_head),
        .empty      (fifo_empty),
        .count      (fifo_cnt),
        .count_next (fifo_cnt_next)
    );

    srb_irq_ctrl #(.W(REG_W)) irq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .dout_we       (wr_dout),
        .ack_we        (wr_ack),
        .wdata         (bus_wdata),
        .rx_level_next (fifo_cnt_next != '0),
        .mask          (r_q.mask),
        .raw           (raw),
        .ack_val       (ack_val),
        .masked        (masked),
        .irq           (irq)
    );

    srb_tx_port #(.BYTE_W(8)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (wr_dout),
        .send_byte (bus_wdata[7:0]),
        .tx_byte   (tx_byte),
        .tx_strobe (tx_strobe)
    );

    assert_rx_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raw[IRQ_RX_BIT] == (fifo_cnt != '0));
    assert_mask_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '0) |-> !irq);
    assert_rx_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.rxctl[RX_EN_BIT] |-> (rx_space == '0));
    assert_peek_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && word == WORD_W'(IDX_PEEK) && !rx_valid) |=> $stable(fifo_cnt));
endmodule

// File: tb/serial_regblock_tb_top.sv
module serial_regblock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [4:0]  rx_space;
    logic [7:0]  tx_byte;
    logic        tx_strobe, irq;

    int tests = 0, fails = 0;
    logic [7:0] mq[$];
    bit   rx_en = 0;
    logic tx_seen;
    logic [7:0] tx_seen_byte;
    logic [31:0] d;

    always #4 clk = ~clk;

    serial_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_space(rx_space),
        .tx_byte(tx_byte), .tx_strobe(tx_strobe), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        tx_seen = tx_strobe; tx_seen_byte = tx_byte;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        if (rx_en && mq.size() < 16) mq.push_back(b);
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = 32'h0140_0000;
        if (mq.size() != 0) s = s | 32'h0001_0000 | {24'h0, mq[0]};
        return s;
    endfunction

    function automatic logic [4:0] exp_space();
        return rx_en ? 5'(16 - mq.size()) : 5'd0;
    endfunction

    task automatic pop_check(input string req);
        logic [31:0] v;
        logic [31:0] e;
        e = exp_stat();
        rd(6'h20, v);
        check(req, "pop status word", v, e);
        if (mq.size() != 0) void'(mq.pop_front());
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state across all word offsets
        check("R1", "irq after reset", {31'h0, irq}, 32'h0);
        check("R1", "rx_space after reset", {27'h0, rx_space}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            e = (i == 8 || i == 9) ? 32'h0140_0000 : 32'h0;
            rd(6'(i * 4), d);
            check("R1", $sformatf("reset read word %0d", i), d, e);
        end
        mq.delete();

        // R2: storage offsets with address low bits set
        begin
            logic [5:0] sto[4] = '{6'h00, 6'h04, 6'h08, 6'h2C};
            for (int i = 0; i < 4; i++) begin
                logic [31:0] pat;
                pat = 32'hA5C3_0000 ^ (32'h1111_1111 * (i + 1)) & ~32'h8;
                wr(sto[i] | 6'h3, pat);
                rd(sto[i] | 6'h1, d);
                check("R2", $sformatf("storage %h", sto[i]), d, pat);
                wr(sto[i], 32'h0);
            end
        end
        begin
            logic [5:0] un[6] = '{6'h0C, 6'h10, 6'h14, 6'h18, 6'h28, 6'h3C};
            for (int i = 0; i < 6; i++) begin
                wr(un[i], 32'hFFFF_FFFF);
                rd(un[i], d);
                check("R2", $sformatf("unmapped %h", un[i]), d, 32'h0);
            end
        end

        // R7: receiver disabled ignores bytes
        push(8'h11);
        rd(6'h24, d);
        check("R7", "disabled receiver ignores byte", d, 32'h0140_0000);
        check("R7", "rx_space while disabled", {27'h0, rx_space}, 32'h0);

        wr(6'h08, 32'h8); rx_en = 1;
        check("R7", "rx_space enabled empty", {27'h0, rx_space}, 32'd16);

        // R6: push 20, keep 16
        for (int i = 0; i < 20; i++) push(8'h30 + 8'(i));
        check("R6", "rx_space when full", {27'h0, rx_space}, 32'h0);
        rd(6'h34, d);
        check("R8", "raw rx bit with data", d, 32'h8);
        wr(6'h30, 32'h8);
        rd(6'h34, d);
        check("R8", "ack cannot clear rx bit", d, 32'h8);

        // R4/R3: peek twice does not pop
        rd(6'h24, d);
        check("R3", "peek status", d, exp_stat());
        rd(6'h24, d);
        check("R4", "second peek unchanged", d, exp_stat());
        check("R4", "peek keeps count", {27'h0, rx_space}, 32'h0);

        // R5: drain in order
        for (int i = 0; i < 16; i++) pop_check("R5");
        check("R5", "space after drain", {27'h0, rx_space}, 32'd16);
        rd(6'h34, d);
        check("R8", "raw rx bit empty", d, 32'h0);

        // R4: pop on empty
        pop_check("R4");
        check("R4", "pop on empty keeps count", {27'h0, rx_space}, 32'd16);

        // R5: wrap rounds
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 11; i++) push(8'(r * 40 + i * 3 + 1));
            check("R7", "space partial", {27'h0, rx_space}, {27'h0, exp_space()});
            for (int i = 0; i < 11; i++) pop_check("R5");
        end

        // R12: push and pop in the same cycle
        push(8'hE1); push(8'hE2); push(8'hE3);
        begin
            logic [31:0] e;
            e = exp_stat();
            @(negedge clk);
            bus_addr = 6'h20; bus_rd = 1'b1; rx_byte = 8'hE4; rx_valid = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0; rx_valid = 1'b0;
            check("R12", "pop data with push", bus_rdata, e);
            void'(mq.pop_front()); mq.push_back(8'hE4);
            check("R12", "count unchanged", {27'h0, rx_space}, 32'd13);
        end
        while (mq.size() != 0) pop_check("R12");

        // R9: data out
        wr(6'h1C, 32'h0000_12A5);
        check("R9", "tx strobe", {31'h0, tx_seen}, 32'h1);
        check("R9", "tx byte", {24'h0, tx_seen_byte}, 32'hA5);
        @(negedge clk);
        check("R9", "tx strobe one cycle", {31'h0, tx_strobe}, 32'h0);
        rd(6'h1C, d);
        check("R2", "dout readback", d, 32'h0000_12A5);
        rd(6'h34, d);
        check("R9", "raw after dout", d, 32'h3);

        // R11: mask
        check("R11", "irq masked off", {31'h0, irq}, 32'h0);
        wr(6'h2C, 32'h1);
        check("R11", "irq with mask bit0", {31'h0, irq}, 32'h1);
        rd(6'h38, d);
        check("R11", "masked reg", d, 32'h1);

        // R10: pending quirk
        wr(6'h30, 32'h3);
        rd(6'h34, d);
        check("R10", "pending ack keeps bit0", d, 32'h1);
        rd(6'h30, d);
        check("R10", "ack stores applied value", d, 32'h2);
        check("R11", "irq still high", {31'h0, irq}, 32'h1);
        wr(6'h30, 32'h1);
        rd(6'h34, d);
        check("R10", "second ack clears bit0", d, 32'h0);
        check("R11", "irq low after ack", {31'h0, irq}, 32'h0);

        // R11: rx interrupt follows level
        wr(6'h2C, 32'h8);
        push(8'h5A);
        check("R11", "irq on rx data", {31'h0, irq}, 32'h1);
        rd(6'h38, d);
        check("R11", "masked rx", d, 32'h8);
        pop_check("R8");
        check("R8", "irq drops after pop", {31'h0, irq}, 32'h0);

        finish_run();
    end
endmodule